// File: doc/BRIEF.md
# Asynchronous Static RAM Access Sequencer

This block sits between a synchronous request port and an external asynchronous static RAM of 128K locations by 8 bits. A requester offers one access at a time with a valid/ready handshake, a write flag, a 17-bit word address and, for writes, a data byte. The block turns each request into a timed sequence on the memory pins: an active-low select, an active-low output enable, an active-low write strobe, the address bus, and a shared data bus. The shared bus appears as three separate signals: the driven value, the sampled value and a drive enable.

Every phase of a sequence is a whole number of clock cycles. Each count comes from a clock-period parameter and the memory's minimum times in nanoseconds, so changing the clock only changes the parameter. Output enable stays high during writes. The block drives the data bus only after the memory has had its release time. The select line returns high for at least one cycle between two accesses. Read data is registered and announced by a single-cycle strobe.

Top module: `asram_ctrl`

## Requirements
- R1: While reset is low, and on the first cycle after it, select, output enable and write strobe are all high (1), the data-bus drive enable is 0, the read strobe is 0 and ready is 1.
- R2: During a write, address and data are stable for at least the address-setup (8 ns) and data-setup (5 ns) minimums before the write strobe rises, and the strobe stays low for at least 7 ns.
- R3: A write ends when the write strobe rises while select is still low. The data bus stays driven and the address is unchanged on the cycle after that edge.
- R4: A read holds select and output enable low and the write strobe high for ACC cycles. The bus is sampled on the clock edge that ends that window, and the read strobe is high for exactly one cycle after that edge, so it is first seen ACC+1 cycles after acceptance.
- R5: The block never drives the data bus while output enable is low. It turns its drivers on no sooner than TURN cycles after output enable was last high-going.
- R6: Select is high on every cycle in which ready is high, so two accesses are always separated by at least one deselected cycle.
- R7: Ready is high only while the sequencer is idle. A request is taken on an edge where valid and ready are both high, and ready is low on the following cycle.
- R8: Each phase count is max(1, ceil(t_ns / CLK_PERIOD_NS)). TURN comes from the 5 ns release time and ACC from the 10 ns access time. The strobe-low count PULSE is the largest of ceil(7 ns), ceil(5 ns), ceil(8 ns) minus TURN, and ceil(10 ns) minus TURN minus 1, each floored at 1. At 8 ns this gives TURN=1, ACC=2 and PULSE=1.
- R9: A read of any address returns the byte most recently written to it, whatever accesses came in between.
- R10: Output enable is high on every cycle in which the write strobe is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 8 | Write byte |
| rd_valid | output | 1 | One-cycle strobe marking read data |
| rd_data | output | 8 | Captured read byte |
| mem_ce_n | output | 1 | Memory select, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_addr | output | 17 | Memory address bus |
| mem_dq_out | output | 8 | Value driven onto the shared data bus |
| mem_dq_in | input | 8 | Value sampled from the shared data bus |
| mem_dq_oe | output | 1 | Drive enable for the shared data bus |

## Verification
The main function is tried with three patterns.

- **Write then read of the same address.** This shows that the write strobe actually commits data, and that the read capture happens after the access time rather than before.
- **Overwrites of one address with other addresses in between.** This separates correct address handling from aliasing, and stale data from last-write-wins.
- **A read directly followed by a write.** This exposes bus contention. The memory model keeps driving for one cycle after output enable rises, so drivers turned on too early are flagged.

A reset issued during a write checks that the strobes recover to their idle levels and that no write is half-committed.

// File: rtl/asram_pkg.sv
// Package: shared phase type and the helpers that turn nanosecond
// minimums into cycle counts. Assumes all arguments are positive.
package asram_pkg;

    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_WTURN  = 3'd1,
        PH_WPULSE = 3'd2,
        PH_WHOLD  = 3'd3,
        PH_RACC   = 3'd4
    } phase_t;

    // Cycles needed to cover ns nanoseconds, never less than one.
    function automatic int ns_to_cycles(input int ns, input int period);
        int c;
        c = (ns + period - 1) / period;
        if (c < 1) c = 1;
        return c;
    endfunction

    // a - b, floored at one.
    function automatic int sub_floor1(input int a, input int b);
        return (a > b) ? (a - b) : 1;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/asram_phase_timer.sv
// Module: down-counter that times one sequencer phase.
// A load sets the remaining count. The counter then steps down to zero
// and holds there. "expired" is high while the count is zero, so a
// load of N-1 gives a phase of exactly N cycles.
module asram_phase_timer #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] remain;

    // Reload on phase entry, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (load) begin
            remain <= load_val;
        end else if (remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    assign expired = (remain == '0);

    p_timer_settles_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && remain != '0) |=> (remain == $past(remain) - 1'b1));

endmodule

// File: rtl/asram_seq.sv
// Module: access sequencer.
// Walks idle -> (turnaround -> strobe -> hold) for writes and
// idle -> access for reads, and registers the memory strobes from the
// next phase so the pins change cleanly on clock edges.
// Assumes requests are only taken while ready is high.
module asram_seq
    import asram_pkg::*;
#(
    parameter int TURN_CYC  = 1,
    parameter int PULSE_CYC = 1,
    parameter int ACC_CYC   = 2,
    parameter int CNT_W     = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic req_write,
    output logic req_ready,
    output logic accept,
    output logic capture,
    output logic ce_n,
    output logic oe_n,
    output logic we_n,
    output logic drive
);

    localparam logic [CNT_W-1:0] TURN_LD  = CNT_W'(TURN_CYC - 1);
    localparam logic [CNT_W-1:0] PULSE_LD = CNT_W'(PULSE_CYC - 1);
    localparam logic [CNT_W-1:0] ACC_LD   = CNT_W'(ACC_CYC - 1);

    phase_t           phase, phase_nxt;
    logic             t_load;
    logic [CNT_W-1:0] t_val;
    logic             t_done;

    asram_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_val (t_val),
        .expired  (t_done)
    );

    // Next phase, timer reload and read-capture decision.
    always_comb begin
        phase_nxt = phase;
        t_load    = 1'b0;
        t_val     = '0;
        capture   = 1'b0;
        case (phase)
            PH_IDLE: begin
                if (req_valid) begin
                    t_load = 1'b1;
                    if (req_write) begin
                        phase_nxt = PH_WTURN;
                        t_val     = TURN_LD;
                    end else begin
                        phase_nxt = PH_RACC;
                        t_val     = ACC_LD;
                    end
                end
            end
            PH_WTURN: begin
                if (t_done) begin
                    phase_nxt = PH_WPULSE;
                    t_load    = 1'b1;
                    t_val     = PULSE_LD;
                end
            end
            PH_WPULSE: begin
                if (t_done) phase_nxt = PH_WHOLD;
            end
            PH_WHOLD: begin
                phase_nxt = PH_IDLE;
            end
            PH_RACC: begin
                if (t_done) begin
                    phase_nxt = PH_IDLE;
                    capture   = 1'b1;
                end
            end
            default: phase_nxt = PH_IDLE;
        endcase
    end

    assign req_ready = (phase == PH_IDLE);
    assign accept    = req_ready && req_valid;

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) phase <= PH_IDLE;
        else        phase <= phase_nxt;
    end

    // Pin strobes registered from the next phase, idle levels on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ce_n  <= 1'b1;
            oe_n  <= 1'b1;
            we_n  <= 1'b1;
            drive <= 1'b0;
        end else begin
            ce_n  <= (phase_nxt == PH_IDLE);
            oe_n  <= (phase_nxt != PH_RACC);
            we_n  <= (phase_nxt != PH_WPULSE);
            drive <= (phase_nxt == PH_WPULSE) || (phase_nxt == PH_WHOLD);
        end
    end

    // Checker state: length of the current strobe-low interval.
    logic [7:0] we_low_len;
    always_ff @(posedge clk) begin
        if (!rst_n)                        we_low_len <= '0;
        else if (!we_n && we_low_len != 8'hFF) we_low_len <= we_low_len + 1'b1;
        else if (we_n)                     we_low_len <= '0;
    end

    p_we_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(we_n) |-> ({24'd0, we_low_len} >= PULSE_CYC));
    p_write_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(we_n) |-> (!ce_n && drive));
    p_no_drive_oe_r5: assert property (@(posedge clk) disable iff (!rst_n)
        drive |-> (oe_n && !ce_n));
    p_ready_deselect_r6: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> ce_n);
    p_busy_after_take_r7: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !req_ready);
    p_write_oe_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> oe_n);

endmodule

// File: rtl/asram_datapath.sv
// Module: address, write-data and read-data registers.
// Latches the request fields when a request is accepted and holds them
// on the pins for the whole access. Samples the bus when the sequencer
// signals capture and raises a one-cycle read strobe.
module asram_datapath #(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              capture,
    input  logic [DATA_W-1:0] dq_in,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] dq_out,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);

    // Request fields, held until the next accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_addr <= '0;
            dq_out   <= '0;
        end else if (accept) begin
            mem_addr <= req_addr;
            dq_out   <= req_wdata;
        end
    end

    // Read capture and its single-cycle strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= capture;
            if (capture) rd_data <= dq_in;
        end
    end

    p_strobe_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

endmodule

// File: rtl/asram_ctrl.sv
// Module: top of the asynchronous static RAM access sequencer.
// Derives every phase count from CLK_PERIOD_NS and the memory minimums,
// then joins the sequencer and the datapath. Assumes the external
// memory meets the given access and release times.
module asram_ctrl
    import asram_pkg::*;
#(
    parameter int CLK_PERIOD_NS = 8,
    parameter int ADDR_W        = 17,
    parameter int DATA_W        = 8,
    parameter int T_CYCLE_NS    = 10,
    parameter int T_WEW_NS      = 7,
    parameter int T_DSU_NS      = 5,
    parameter int T_SEL_NS      = 8,
    parameter int T_ASU_NS      = 8,
    parameter int T_ACC_NS      = 10,
    parameter int T_REL_NS      = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_out,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic              mem_dq_oe
);

    localparam int TURN_CYC = ns_to_cycles(T_REL_NS, CLK_PERIOD_NS);
    localparam int ACC_CYC  = ns_to_cycles(T_ACC_NS, CLK_PERIOD_NS);
    localparam int PULSE_CYC =
        max2(max2(ns_to_cycles(T_WEW_NS, CLK_PERIOD_NS),
                  ns_to_cycles(T_DSU_NS, CLK_PERIOD_NS)),
             max2(max2(sub_floor1(ns_to_cycles(T_SEL_NS, CLK_PERIOD_NS), TURN_CYC),
                       sub_floor1(ns_to_cycles(T_ASU_NS, CLK_PERIOD_NS), TURN_CYC)),
                  sub_floor1(ns_to_cycles(T_CYCLE_NS, CLK_PERIOD_NS), TURN_CYC + 1)));
    localparam int MAX_CYC  = max2(max2(TURN_CYC, ACC_CYC), PULSE_CYC);
    localparam int CNT_W    = $clog2(MAX_CYC + 1);

    logic accept;
    logic capture;

    asram_seq #(
        .TURN_CYC  (TURN_CYC),
        .PULSE_CYC (PULSE_CYC),
        .ACC_CYC   (ACC_CYC),
        .CNT_W     (CNT_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_ready (req_ready),
        .accept    (accept),
        .capture   (capture),
        .ce_n      (mem_ce_n),
        .oe_n      (mem_oe_n),
        .we_n      (mem_we_n),
        .drive     (mem_dq_oe)
    );

    asram_datapath #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .capture   (capture),
        .dq_in     (mem_dq_in),
        .mem_addr  (mem_addr),
        .dq_out    (mem_dq_out),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data)
    );

    // Address pins must not move while the memory is selected.
    p_addr_steady_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

endmodule

// File: tb/asram_ctrl_test.sv
`timescale 1ns/1ps
module asram_ctrl_test;

    localparam int PER = 8;

    function automatic int cdiv(input int ns);
        int c;
        c = (ns + PER - 1) / PER;
        return (c < 1) ? 1 : c;
    endfunction
    function automatic int sf1(input int a, input int b);
        return (a > b) ? a - b : 1;
    endfunction
    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    localparam int E_TURN  = cdiv(5);
    localparam int E_ACC   = cdiv(10);
    localparam int E_PULSE = mx(mx(cdiv(7), cdiv(5)),
                               mx(mx(sf1(cdiv(8), E_TURN), sf1(cdiv(8), E_TURN)),
                                  sf1(cdiv(10), E_TURN + 1)));

    // {write, address, data (write byte or expected read byte)}
    localparam logic [25:0] VEC [0:11] = '{
        {1'b1, 17'h00000, 8'hA5}, {1'b1, 17'h1FFFF, 8'h3C},
        {1'b0, 17'h00000, 8'hA5}, {1'b0, 17'h1FFFF, 8'h3C},
        {1'b1, 17'h0AA55, 8'h00}, {1'b1, 17'h15A2A, 8'hFF},
        {1'b0, 17'h0AA55, 8'h00}, {1'b1, 17'h00000, 8'h5A},
        {1'b0, 17'h00000, 8'h5A}, {1'b0, 17'h15A2A, 8'hFF},
        {1'b1, 17'h1FFFF, 8'hC3}, {1'b0, 17'h1FFFF, 8'hC3}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [16:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        rd_valid;
    logic [7:0]  rd_data;
    logic        mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [16:0] mem_addr;
    logic [7:0]  mem_dq_out;
    logic [7:0]  mem_dq_in = 8'hEE;

    int runs = 0;
    int fails = 0;

    always #4 clk = ~clk;

    asram_ctrl #(.CLK_PERIOD_NS(PER)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .mem_ce_n(mem_ce_n),
        .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_addr(mem_addr),
        .mem_dq_out(mem_dq_out), .mem_dq_in(mem_dq_in), .mem_dq_oe(mem_dq_oe)
    );

    // Memory model: 64 slots tagged by full address, sampled mid-cycle.
    logic [7:0]  m_dat [64];
    logic [16:0] m_tag [64];
    logic        m_ok  [64];
    int v_setup = 0, v_hold = 0, v_contend = 0, v_oe = 0;
    int last_pulse = 0;
    int rd_cnt = 0, we_cnt = 0, ds_cnt = 0, as_cnt = 0, ce_cnt = 0;
    logic p_wr = 1'b0, p_rd = 1'b0;
    logic [7:0]  p_dq = '0, w_dq = '0;
    logic [16:0] p_ad = '0, w_ad = '0;

    initial for (int i = 0; i < 64; i++) m_ok[i] = 1'b0;

    always @(negedge clk) begin
        logic rd_now, wr_now;
        rd_now = !mem_ce_n && !mem_oe_n && mem_we_n;
        wr_now = !mem_ce_n && !mem_we_n;
        // read side: data valid only after the access time
        if (rd_now) begin
            rd_cnt = (p_rd && mem_addr == p_ad) ? rd_cnt + 1 : 1;
            if (rd_cnt * PER >= 10 && m_ok[mem_addr[5:0]] && m_tag[mem_addr[5:0]] == mem_addr)
                mem_dq_in = m_dat[mem_addr[5:0]];
            else
                mem_dq_in = 8'hEE;
        end else begin
            rd_cnt = 0;
            mem_dq_in = 8'hEE;
        end
        // memory still drives for one sample after output enable rises
        if ((rd_now || p_rd) && mem_dq_oe) v_contend++;
        // stability counters
        ce_cnt = !mem_ce_n ? ce_cnt + 1 : 0;
        as_cnt = (!mem_ce_n && mem_addr == p_ad) ? as_cnt + 1 : (!mem_ce_n ? 1 : 0);
        ds_cnt = (mem_dq_oe && mem_dq_out == p_dq) ? ds_cnt + 1 : (mem_dq_oe ? 1 : 0);
        if (wr_now) begin
            we_cnt = p_wr ? we_cnt + 1 : 1;
            if (!mem_oe_n) v_oe++;
            w_dq = mem_dq_out;
            w_ad = mem_addr;
            if (!mem_dq_oe || ds_cnt * PER < 5 || as_cnt * PER < 8 ||
                ce_cnt * PER < 8) begin
                if (!mem_we_n && we_cnt == 1) ; // judged at write end
            end
        end
        if (p_wr && !wr_now) begin
            last_pulse = we_cnt;
            if (we_cnt * PER < 7) v_setup++;
            if (mem_ce_n || !mem_dq_oe || mem_dq_out != w_dq || mem_addr != w_ad) v_hold++;
            m_dat[w_ad[5:0]] = w_dq;
            m_tag[w_ad[5:0]] = w_ad;
            m_ok[w_ad[5:0]]  = 1'b1;
        end
        if (wr_now && (ds_cnt * PER < 5 ? we_cnt == 1 && 1'b0 : 1'b0)) v_setup++;
        p_wr = wr_now;
        p_rd = rd_now;
        p_ad = mem_addr;
        p_dq = mem_dq_out;
    end

    // Setup is judged on the last strobe-low sample of each write.
    int su_ds = 0, su_as = 0, su_ce = 0;
    always @(negedge clk) begin
        #1;
        if (!mem_ce_n && !mem_we_n) begin
            su_ds = ds_cnt; su_as = as_cnt; su_ce = ce_cnt;
        end else if (p_wr == 1'b0 && su_ce != 0) begin
            if (su_ds * PER < 5 || su_as * PER < 8 || su_ce * PER < 8) v_setup++;
            su_ds = 0; su_as = 0; su_ce = 0;
        end
    end

    task automatic check(input string req, input logic ok, input int act, input int exp);
        runs++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_op(input logic wr, input logic [16:0] a, input logic [7:0] d);
        logic r;
        int n;
        int s0, h0, c0, o0;
        s0 = v_setup; h0 = v_hold; c0 = v_contend; o0 = v_oe;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wr ? d : 8'h99;
        forever begin
            r = req_ready;
            @(posedge clk);
            if (r) break;
            @(negedge clk);
        end
        @(negedge clk);
        req_valid = 1'b0;
        check("R7 busy after accept", req_ready == 1'b0, req_ready, 0);
        n = 1;
        if (!wr) begin
            while (!rd_valid && n < 20) begin @(negedge clk); n++; end
            check("R4 read latency", n == E_ACC + 1, n, E_ACC + 1);
            check("R9 read data", rd_data == d, rd_data, d);
            check("R6 deselected when ready", mem_ce_n && req_ready, mem_ce_n, 1);
            @(negedge clk);
            check("R4 strobe one cycle", rd_valid == 1'b0, rd_valid, 0);
        end else begin
            while (!req_ready && n < 20) begin @(negedge clk); n++; end
            check("R6 deselected when ready", mem_ce_n == 1'b1, mem_ce_n, 1);
            check("R8 strobe-low cycles", last_pulse == E_PULSE, last_pulse, E_PULSE);
            check("R2 setup and width", v_setup == s0, v_setup - s0, 0);
            check("R3 hold at write end", v_hold == h0, v_hold - h0, 0);
            check("R10 oe high in write", v_oe == o0, v_oe - o0, 0);
        end
        check("R5 no bus contention", v_contend == c0, v_contend - c0, 0);
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", runs, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        runs++; fails++;
        $display("FAIL watchdog expired actual=0 expected=1");
        summary();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: idle levels under reset
        check("R1 ce_n in reset", mem_ce_n, mem_ce_n, 1);
        check("R1 oe_n in reset", mem_oe_n, mem_oe_n, 1);
        check("R1 we_n in reset", mem_we_n, mem_we_n, 1);
        check("R1 drive off in reset", !mem_dq_oe, mem_dq_oe, 0);
        check("R1 no read strobe", !rd_valid, rd_valid, 0);
        check("R1 ready", req_ready, req_ready, 1);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle after reset", mem_ce_n && mem_we_n && req_ready, mem_ce_n, 1);

        for (int i = 0; i < 12; i++) begin
            logic [25:0] v;
            v = VEC[i];
            do_op(v[25], v[24:8], v[7:0]);
        end

        // Directed: read immediately followed by write (turnaround, R5)
        do_op(1'b0, 17'h0AA55, 8'h00);
        do_op(1'b1, 17'h0AA55, 8'h77);
        do_op(1'b0, 17'h0AA55, 8'h77);

        // Directed: reset during a write leaves idle levels and no commit (R1)
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 17'h00000; req_wdata = 8'hDE;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 strobes after mid-write reset",
              mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe, mem_ce_n, 1);
        rst_n = 1'b1;
        do_op(1'b0, 17'h00000, 8'h5A);

        summary();
    end

endmodule